// File: doc/BRIEF.md
# Message Digest Engine Register Front End

This block is the bus-facing control and status layer of a message-digest accelerator. Software writes a control word that picks the digest algorithm and input data type and can restart a computation. It writes message words into an input port. It writes a start word that gives the number of valid bits in the final word and can launch the final digest computation. It reads a status word with two flags: one says the core can take more input, the other says the digest is complete.

An interrupt enable word holds one enable per flag. The level interrupt output is high while any flag is set together with its enable. The hashing core sits outside this block and connects through a small handshake. The core gets one-cycle pulses for init, digest-calculate and each input word, and it sends back pulses for "ready for next block" and "digest done". The digest words come back through an indexed read window. How many words that window shows depends on the selected algorithm.

Register word addresses: CTRL = 0, DIN = 1, START = 2, STATUS = 3, IMR = 4. The digest window covers addresses MAX_WORDS to 2*MAX_WORDS-1 (16..31 by default). Reads of any other address return 0.

Top module: `hash_ctrl_regs`

## Requirements
- R1: CTRL holds the algorithm code in bits [3:0] and the data type in bits [5:4]. Both read back and drive `core_algo_o` and `core_dtype_o`.
- R2: Writing CTRL with bit 8 set raises `core_init_o` for exactly the cycle after the write. Bit 8 always reads back as 0.
- R3: START holds the last-word valid-bit count in bits [4:0], which reads back and drives `core_nvbits_o`. Writing START with bit 8 set raises `core_dcal_o` for the cycle after the write. Bit 8 always reads back as 0.
- R4: A write to DIN raises `core_din_valid_o` for the next cycle, with `core_din_o` carrying the written word. DIN reads back as 0.
- R5: STATUS bit 0 (input ready) is set by `core_blk_ready_i` and cleared by a DIN write. If both happen in the same cycle, the set wins.
- R6: STATUS bit 1 (digest complete) is set by `core_dgst_done_i` and cleared by a DIN write or by a CTRL write with bit 8 set. If a set and a clear happen in the same cycle, the set wins.
- R7: IMR bit 0 enables input ready and bit 1 enables digest complete; both bits read back. `irq_o` = (ready AND its enable) OR (complete AND its enable).
- R8: The algorithm codes and their digest word counts are: 0 (SHA-1) 5, 1 (MD5) 4, 2 (SHA-224) 7, 3 (SHA-256) 8, 12 (SHA-384) 12, 13 (SHA-512/224) 7, 14 (SHA-512/256) 8, 15 (SHA-512) 16. Window index i below the count returns digest word i from `core_digest_i[i*32 +: 32]`.
- R9: Window indices at or above the count return 0. An unassigned algorithm code has a count of 0.
- R10: After reset, every register, flag, pulse and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Bus write when 1, read when 0 |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational from addr_i |
| irq_o | output | 1 | Level interrupt |
| core_algo_o | output | 4 | Selected algorithm code |
| core_dtype_o | output | 2 | Selected data type |
| core_nvbits_o | output | 5 | Valid bits of last word |
| core_init_o | output | 1 | Init pulse |
| core_dcal_o | output | 1 | Digest-calculate pulse |
| core_din_valid_o | output | 1 | Input word pulse |
| core_din_o | output | DW | Input word |
| core_blk_ready_i | input | 1 | Core ready for next block (pulse) |
| core_dgst_done_i | input | 1 | Digest complete (pulse) |
| core_digest_i | input | MAX_WORDS*DW | Digest words, word i at [i*DW +: DW] |

## Verification
The bench reads every window index under every assigned algorithm code and under one unassigned code. A count table with an error, or a window that does not mask by count, would show a stale digest word at the edge index. It drives a flag set and a clear in the same cycle. A design with the wrong priority would lose an input-ready or digest-complete event and miss an interrupt. It also reads init and digest-calculate back after writing them, and checks that each pulse lasts one cycle. A sticky bit would either read as 1 or repeat the command to the core.

// File: rtl/hash_ctrl_pkg.sv
package hash_ctrl_pkg;
  localparam int REG_CTRL   = 0;
  localparam int REG_DIN    = 1;
  localparam int REG_START  = 2;
  localparam int REG_STATUS = 3;
  localparam int REG_IMR    = 4;
  localparam int CMD_BIT    = 8;

  typedef enum logic [3:0] {
    ALG_SHA1     = 4'd0,
    ALG_MD5      = 4'd1,
    ALG_SHA224   = 4'd2,
    ALG_SHA256   = 4'd3,
    ALG_SHA384   = 4'd12,
    ALG_S512_224 = 4'd13,
    ALG_S512_256 = 4'd14,
    ALG_SHA512   = 4'd15
  } algo_e;

  function automatic logic [4:0] digest_words(input logic [3:0] a);
    case (a)
      ALG_SHA1:     return 5'd5;
      ALG_MD5:      return 5'd4;
      ALG_SHA224:   return 5'd7;
      ALG_SHA256:   return 5'd8;
      ALG_SHA384:   return 5'd12;
      ALG_S512_224: return 5'd7;
      ALG_S512_256: return 5'd8;
      ALG_SHA512:   return 5'd16;
      default:      return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/hash_ctrl_cfg.sv
module hash_ctrl_cfg
  import hash_ctrl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DW     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [3:0]        algo_o,
  output logic [1:0]        dtype_o,
  output logic [4:0]        nvb_o,
  output logic              ie_in_o,
  output logic              ie_dc_o,
  output logic              init_o,
  output logic              dcal_o,
  output logic              din_valid_o,
  output logic [DW-1:0]     din_o,
  output logic              init_wr_o,
  output logic              din_wr_o
);
  logic wr_ctrl, wr_start, wr_imr;

  assign wr_ctrl   = wr_i && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_start  = wr_i && (addr_i == ADDR_W'(REG_START));
  assign wr_imr    = wr_i && (addr_i == ADDR_W'(REG_IMR));
  assign din_wr_o  = wr_i && (addr_i == ADDR_W'(REG_DIN));
  assign init_wr_o = wr_ctrl && wdata_i[CMD_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      algo_o      <= '0;
      dtype_o     <= '0;
      nvb_o       <= '0;
      ie_in_o     <= 1'b0;
      ie_dc_o     <= 1'b0;
      init_o      <= 1'b0;
      dcal_o      <= 1'b0;
      din_valid_o <= 1'b0;
      din_o       <= '0;
    end else begin
      init_o      <= init_wr_o;
      dcal_o      <= wr_start && wdata_i[CMD_BIT];
      din_valid_o <= din_wr_o;
      if (din_wr_o) din_o <= wdata_i;
      if (wr_ctrl) begin
        algo_o  <= wdata_i[3:0];
        dtype_o <= wdata_i[5:4];
      end
      if (wr_start) nvb_o <= wdata_i[4:0];
      if (wr_imr) begin
        ie_in_o <= wdata_i[0];
        ie_dc_o <= wdata_i[1];
      end
    end
  end

  // R2
  init_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o && !init_wr_o |=> !init_o);
  // R3
  dcal_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_start && wdata_i[CMD_BIT]) |=> dcal_o);
  // R4
  din_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_wr_o |=> (din_valid_o && din_o == $past(wdata_i)));
endmodule

// File: rtl/hash_ctrl_status.sv
module hash_ctrl_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic blk_ready_i,
  input  logic dgst_done_i,
  input  logic din_wr_i,
  input  logic init_wr_i,
  input  logic ie_in_i,
  input  logic ie_dc_i,
  output logic in_rdy_o,
  output logic dc_o,
  output logic irq_o
);
  // set has priority over clear on both flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rdy_o <= 1'b0;
      dc_o     <= 1'b0;
    end else begin
      if (blk_ready_i)   in_rdy_o <= 1'b1;
      else if (din_wr_i) in_rdy_o <= 1'b0;
      if (dgst_done_i)                dc_o <= 1'b1;
      else if (din_wr_i || init_wr_i) dc_o <= 1'b0;
    end
  end

  assign irq_o = (in_rdy_o && ie_in_i) || (dc_o && ie_dc_i);

  // R5
  rdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_ready_i |=> in_rdy_o);
  // R6
  dc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((din_wr_i || init_wr_i) && !dgst_done_i) |=> !dc_o);
  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie_in_i && !ie_dc_i) |-> !irq_o);
endmodule

// File: rtl/hash_ctrl_rdmux.sv
module hash_ctrl_rdmux
  import hash_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DW        = 32,
  parameter int MAX_WORDS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [3:0]            algo_i,
  input  logic [1:0]            dtype_i,
  input  logic [4:0]            nvb_i,
  input  logic                  ie_in_i,
  input  logic                  ie_dc_i,
  input  logic                  in_rdy_i,
  input  logic                  dc_i,
  input  logic [MAX_WORDS*DW-1:0] digest_i,
  output logic [DW-1:0]         rdata_o
);
  localparam int IDX_W = $clog2(MAX_WORDS);

  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic [4:0]       cnt;

  assign in_win = (addr_i[ADDR_W-1:IDX_W] == (ADDR_W-IDX_W)'(1));
  assign idx    = addr_i[IDX_W-1:0];
  assign cnt    = digest_words(algo_i);

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      if (int'(idx) < int'(cnt)) rdata_o = digest_i[idx*DW +: DW];
    end else begin
      case (int'(addr_i))
        REG_CTRL:   rdata_o = DW'({dtype_i, algo_i});
        REG_START:  rdata_o = DW'(nvb_i);
        REG_STATUS: rdata_o = DW'({dc_i, in_rdy_i});
        REG_IMR:    rdata_o = DW'({ie_dc_i, ie_in_i});
        default:    rdata_o = '0;
      endcase
    end
  end

  // R9
  md5_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_win && algo_i == ALG_MD5 && int'(idx) == 4) |-> rdata_o == '0);
endmodule

// File: rtl/hash_ctrl_regs.sv
module hash_ctrl_regs #(
  parameter int ADDR_W    = 6,
  parameter int DW        = 32,
  parameter int MAX_WORDS = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic                    irq_o,
  output logic [3:0]              core_algo_o,
  output logic [1:0]              core_dtype_o,
  output logic [4:0]              core_nvbits_o,
  output logic                    core_init_o,
  output logic                    core_dcal_o,
  output logic                    core_din_valid_o,
  output logic [DW-1:0]           core_din_o,
  input  logic                    core_blk_ready_i,
  input  logic                    core_dgst_done_i,
  input  logic [MAX_WORDS*DW-1:0] core_digest_i
);
  logic ie_in, ie_dc, init_wr, din_wr, in_rdy, dc;

  hash_ctrl_cfg #(.ADDR_W(ADDR_W), .DW(DW)) u_cfg (
    .clk_i, .rst_ni,
    .wr_i        (req_i && we_i),
    .addr_i, .wdata_i,
    .algo_o      (core_algo_o),
    .dtype_o     (core_dtype_o),
    .nvb_o       (core_nvbits_o),
    .ie_in_o     (ie_in),
    .ie_dc_o     (ie_dc),
    .init_o      (core_init_o),
    .dcal_o      (core_dcal_o),
    .din_valid_o (core_din_valid_o),
    .din_o       (core_din_o),
    .init_wr_o   (init_wr),
    .din_wr_o    (din_wr)
  );

  hash_ctrl_status u_stat (
    .clk_i, .rst_ni,
    .blk_ready_i (core_blk_ready_i),
    .dgst_done_i (core_dgst_done_i),
    .din_wr_i    (din_wr),
    .init_wr_i   (init_wr),
    .ie_in_i     (ie_in),
    .ie_dc_i     (ie_dc),
    .in_rdy_o    (in_rdy),
    .dc_o        (dc),
    .irq_o
  );

  hash_ctrl_rdmux #(.ADDR_W(ADDR_W), .DW(DW), .MAX_WORDS(MAX_WORDS)) u_rd (
    .clk_i, .rst_ni, .addr_i,
    .algo_i   (core_algo_o),
    .dtype_i  (core_dtype_o),
    .nvb_i    (core_nvbits_o),
    .ie_in_i  (ie_in),
    .ie_dc_i  (ie_dc),
    .in_rdy_i (in_rdy),
    .dc_i     (dc),
    .digest_i (core_digest_i),
    .rdata_o
  );

  // R10
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/sim_hash_ctrl_regs.sv
`timescale 1ns/1ps
module sim_hash_ctrl_regs;
  localparam int AW = 6, DW = 32, MW = 16;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic blk_rdy = 0, dg_done = 0;
  logic [MW*DW-1:0] digest;
  logic [DW-1:0] rdata, din;
  logic irq, init_p, dcal_p, dv;
  logic [3:0] algo;
  logic [1:0] dtype;
  logic [4:0] nvb;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < MW; g++) begin : g_dig
    assign digest[g*DW +: DW] = 32'hD00D_0000 + 32'(g * 17 + 3);
  end

  hash_ctrl_regs #(.ADDR_W(AW), .DW(DW), .MAX_WORDS(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .core_algo_o(algo),
    .core_dtype_o(dtype), .core_nvbits_o(nvb), .core_init_o(init_p),
    .core_dcal_o(dcal_p), .core_din_valid_o(dv), .core_din_o(din),
    .core_blk_ready_i(blk_rdy), .core_dgst_done_i(dg_done),
    .core_digest_i(digest)
  );

  // reference model
  logic [3:0] m_algo; logic [1:0] m_dtype; logic [4:0] m_nvb;
  bit m_iein, m_iedc, m_rdy, m_dc, m_init, m_dcal, m_dv;
  logic [DW-1:0] m_din;

  function automatic int word_cnt(input logic [3:0] a);
    case (a)
      0: return 5;  1: return 4;  2: return 7;  3: return 8;
      12: return 12; 13: return 7; 14: return 8; 15: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_read(input int a);
    if (a >= MW && a < 2*MW)
      return ((a - MW) < word_cnt(m_algo)) ? 32'hD00D_0000 + 32'((a - MW) * 17 + 3) : '0;
    case (a)
      0: return {26'd0, m_dtype, m_algo};
      2: return {27'd0, m_nvb};
      3: return {30'd0, m_dc, m_rdy};
      4: return {30'd0, m_iedc, m_iein};
      default: return '0;
    endcase
  endfunction

  function automatic string rd_tag(input int a);
    if (a >= MW && a < 2*MW) return "R8/R9";
    case (a)
      0: return "R1/R2"; 1: return "R4"; 2: return "R3";
      3: return "R5/R6"; 4: return "R7"; default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_algo = 0; m_dtype = 0; m_nvb = 0; m_iein = 0; m_iedc = 0;
      m_rdy = 0; m_dc = 0; m_init = 0; m_dcal = 0; m_dv = 0; m_din = 0;
    end else begin
      bit w, wd, wi;
      w  = req && we;
      wd = w && addr == 1;
      wi = w && addr == 0 && wdata[8];
      m_init = wi;
      m_dcal = w && addr == 2 && wdata[8];
      m_dv = wd;
      if (wd) m_din = wdata;
      if (w && addr == 0) begin m_algo = wdata[3:0]; m_dtype = wdata[5:4]; end
      if (w && addr == 2) m_nvb = wdata[4:0];
      if (w && addr == 4) begin m_iein = wdata[0]; m_iedc = wdata[1]; end
      if (blk_rdy) m_rdy = 1; else if (wd) m_rdy = 0;
      if (dg_done) m_dc = 1; else if (wd || wi) m_dc = 0;
    end
  end

  task automatic chk(input bit ok, input string req_s, input logic [DW-1:0] act, exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req_s, act, exp_v, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(irq == (m_rdy && m_iein || m_dc && m_iedc), "R7 irq", 32'(irq),
        32'(m_rdy && m_iein || m_dc && m_iedc));
    chk(init_p == m_init, "R2 init pulse", 32'(init_p), 32'(m_init));
    chk(dcal_p == m_dcal, "R3 dcal pulse", 32'(dcal_p), 32'(m_dcal));
    chk(dv == m_dv, "R4 din valid", 32'(dv), 32'(m_dv));
    if (m_dv) chk(din == m_din, "R4 din data", din, m_din);
    chk({dtype, algo} == {m_dtype, m_algo}, "R1 core cfg", 32'({dtype, algo}),
        32'({m_dtype, m_algo}));
    chk(nvb == m_nvb, "R3 nvbits", 32'(nvb), 32'(m_nvb));
    if (req && !we)
      chk(rdata == exp_read(int'(addr)), rd_tag(int'(addr)), rdata, exp_read(int'(addr)));
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    req = 1; we = 1; addr = AW'(a); wdata = d;
    @(negedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(input int a);
    req = 1; we = 0; addr = AW'(a);
    @(negedge clk); #1;
    req = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic core_ev(input bit r, input bit d);
    blk_rdy = r; dg_done = d;
    @(negedge clk); #1;
    blk_rdy = 0; dg_done = 0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R10 reset state of every mapped and unmapped address
    for (int a = 0; a < 2*MW + 4; a++) rd(a);
    chk(irq == 0 && algo == 0 && !dv, "R10 reset outputs", 32'(irq), 0);

    // R1 R2 config with init; bit 8 reads as 0
    wr(0, 32'h0000_0123);  // algo 3, dtype 2, init
    rd(0);
    chk(rdata == 32'h23, "R2 init reads 0", rdata, 32'h23);
    wr(0, 32'h0000_001C);
    rd(0);

    // R8 R9 window for every code, plus unassigned
    for (int c = 0; c < 16; c++) begin
      wr(0, 32'(c));
      for (int i = 0; i < MW; i++) rd(MW + i);
    end

    // R3 start register and dcal pulse, back-to-back
    wr(2, 32'h0000_0118);
    wr(2, 32'h0000_0118);
    rd(2);
    chk(rdata == 32'h18, "R3 dcal reads 0", rdata, 32'h18);
    wr(2, 32'h0000_0007);
    idle(2);

    // R4 data words
    for (int i = 0; i < 5; i++) wr(1, 32'hA5A5_0000 + 32'(i));
    rd(1);

    // R7 enables, R5 input ready
    wr(4, 32'h1);
    rd(4);
    core_ev(1, 0);
    chk(irq == 1, "R7 irq on ready", 32'(irq), 1);
    rd(3);
    wr(1, 32'h1111_2222);
    chk(irq == 0, "R5 ready cleared by din", 32'(irq), 0);
    // R5 simultaneous set and clear: set wins
    blk_rdy = 1; wr(1, 32'h3333_4444); blk_rdy = 0;
    rd(3);
    chk(rdata[0] == 1, "R5 set wins", rdata, 1);

    // R6 digest complete flag
    wr(4, 32'h2);
    core_ev(0, 1);
    chk(irq == 1, "R7 irq on done", 32'(irq), 1);
    wr(0, 32'h0000_0100);   // init clears
    rd(3);
    chk(rdata[1] == 0, "R6 init clears done", rdata, 0);
    core_ev(0, 1);
    wr(0, 32'h0000_0003);   // no init: flag stays
    rd(3);
    chk(rdata[1] == 1, "R6 ctrl without init keeps done", rdata, 2);
    wr(1, 32'h5);           // din clears
    rd(3);
    dg_done = 1; wr(0, 32'h100); dg_done = 0;
    rd(3);
    chk(rdata[1] == 1, "R6 set wins over init", rdata, 2);

    // R7 both masks off: irq low even with both flags set
    core_ev(1, 1);
    wr(4, 32'h0);
    chk(irq == 0, "R7 masked", 32'(irq), 0);
    wr(4, 32'h3);
    rd(4);
    idle(3);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule